// File: doc/BRIEF.md
# PWM Trip Override Stage

This block sits between the complementary outputs of a PWM generator and the output pins. It passes each PWM output through untouched until a trip condition is active. It then replaces that output with a value chosen by a 2-bit action code: high impedance, forced high, forced low, or pass-through. Each output drives two pin signals, a data value and an output enable, so that high impedance can be represented.

There are two kinds of trip source:

- **Latched trip.** A one-shot latch is shared by all outputs. It is set by an external trip input or a one-cycle software force strobe, and it holds until a clear strobe arrives. The one-shot latch is the only source that can hold an override for as long as software wants.
- **Pulse trip.** Each output has a raw compare-event path of its own, also set by an external event input or a force strobe. It overrides its output only for the single cycle in which the registered event pulse is present.

Each pulse source also sets a sticky flag. The flag stays set after the pulse has gone, until its own clear strobe. The latch state and the flags can be read back as one status word.

The one-shot latch is a two-state machine. OST_ARMED moves to OST_TRIPPED on a trip input or a force. OST_TRIPPED moves back to OST_ARMED on a clear strobe, but only when no trip or force arrives in the same cycle.

Each output has two more machines:

- **Event pulse machine.** It enters EVT_PULSE from EVT_QUIET on an event or force. It falls back to EVT_QUIET on the next edge unless the event is still present.
- **Flag machine.** It moves from FLAG_CLEAR to FLAG_SET on an event or force. It moves from FLAG_SET to FLAG_CLEAR on a clear strobe with no event in the same cycle.

Top module: `tz_override`

## Requirements
- R1: After reset the latch and all flags are clear, `status` is zero, every `pin_oe` bit is 1 and every `pin_drv` bit equals its `pwm_in` bit.
- R2: An action code on a tripped output means the following: 0 gives `pin_oe`=0 and `pin_drv`=0; 1 gives `pin_oe`=1 and `pin_drv`=1; 2 gives `pin_oe`=1 and `pin_drv`=0; 3 gives `pin_oe`=1 and `pin_drv`=`pwm_in`. The action code for output i is the bit pair [2i+1:2i] of `act_ost` or `act_evt`.
- R3: An event on `evt_in[i]` or `frc_evt[i]` applies the action `act_evt` of output i for exactly the one clock cycle after the edge that sampled it. Output i then returns to its PWM value if no new event arrives.
- R4: Status bit i+1 is the sticky flag of output i, where output 0 is channel A and output 1 is channel B. The flag is set by an event and stays set on later cycles until `clr_evt[i]` is sampled.
- R5: `ost_in` or `frc_ost` sets the latch (status bit 0). While the latch is set, every output shows its `act_ost` action on all later cycles until `clr_ost` is sampled.
- R6: An event on one output does not change any other output or any other flag.
- R7: A change of `act_ost` while the latch is set changes the outputs in the same cycle, with no clock edge needed.
- R8: When the latch and an event pulse are both active on an output, that output follows `act_ost`.
- R9: A clear strobe sampled in the same cycle as a set (trip, event or force) for the same latch or flag leaves it set.
- R10: Trip inputs have no combinational path to the pins. A trip takes effect only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | NUM_OUT | PWM values from the generator, bit 0 is channel A |
| act_ost | input | 2*NUM_OUT | Per-output action codes used while the latch is set |
| act_evt | input | 2*NUM_OUT | Per-output action codes used during an event pulse |
| ost_in | input | 1 | External one-shot trip request |
| frc_ost | input | 1 | Software force of the one-shot trip, one cycle |
| clr_ost | input | 1 | Clear strobe for the one-shot latch |
| evt_in | input | NUM_OUT | Raw compare event per output |
| frc_evt | input | NUM_OUT | Software force of the compare event per output |
| clr_evt | input | NUM_OUT | Clear strobe for each event flag |
| pin_drv | output | NUM_OUT | Drive value per pin |
| pin_oe | output | NUM_OUT | Output enable per pin, 0 means high impedance |
| status | output | NUM_OUT+1 | Bit 0 is the latch; bit i+1 is the event flag of output i |

## Verification
The bench builds the block with NUM_OUT=2, the complementary pair. At this size it can run every combination of the latched action code, the event action code, the PWM level, and the four trip scenarios (none, event only, latch only, both). It gives channel B a different code mapping from channel A, so any crosstalk between the outputs shows up. Directed sequences then cover the single-cycle pulse, flags that stay set over many cycles, a change of action while the latch is held, the absence of a combinational path from the trip inputs, and a clear strobe that arrives in the same cycle as a set.

// File: rtl/tz_pkg.sv
package tz_pkg;

    typedef enum logic [1:0] {
        ACT_HIZ  = 2'd0,
        ACT_HIGH = 2'd1,
        ACT_LOW  = 2'd2,
        ACT_PASS = 2'd3
    } tz_act_e;

    typedef enum logic {
        OST_ARMED,
        OST_TRIPPED
    } ost_state_e;

    typedef enum logic {
        EVT_QUIET,
        EVT_PULSE
    } evt_state_e;

    typedef enum logic {
        FLAG_CLEAR,
        FLAG_SET
    } flag_state_e;

endpackage

// File: rtl/tz_ost_latch.sv
module tz_ost_latch
    import tz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_in,
    input  logic frc,
    input  logic clr,
    output logic latched
);

    ost_state_e state_q, state_d;
    logic       set_req;

    assign set_req = trip_in | frc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OST_ARMED:   if (set_req)         state_d = OST_TRIPPED;
            OST_TRIPPED: if (clr && !set_req) state_d = OST_ARMED;
            default:                          state_d = OST_ARMED;
        endcase
    end

    always_comb begin
        latched = (state_q == OST_TRIPPED);
    end

    AST_OST_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                        (latched && !clr) |=> latched);              // R5
    AST_OST_SET:    assert property (@(posedge clk) disable iff (!rst_n)
                        set_req |=> latched);                        // R9
    AST_OST_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n)
                        (clr && !set_req) |=> !latched);             // R5

endmodule

// File: rtl/tz_evt_chan.sv
module tz_evt_chan
    import tz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    input  logic frc,
    input  logic clr,
    output logic active,
    output logic flag
);

    evt_state_e  pulse_q, pulse_d;
    flag_state_e flag_q,  flag_d;
    logic        hit;

    assign hit = evt_in | frc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= EVT_QUIET;
            flag_q  <= FLAG_CLEAR;
        end else begin
            pulse_q <= pulse_d;
            flag_q  <= flag_d;
        end
    end

    always_comb begin
        pulse_d = pulse_q;
        unique case (pulse_q)
            EVT_QUIET: if (hit)  pulse_d = EVT_PULSE;
            EVT_PULSE: if (!hit) pulse_d = EVT_QUIET;
            default:             pulse_d = EVT_QUIET;
        endcase
    end

    always_comb begin
        flag_d = flag_q;
        unique case (flag_q)
            FLAG_CLEAR: if (hit)         flag_d = FLAG_SET;
            FLAG_SET:   if (clr && !hit) flag_d = FLAG_CLEAR;
            default:                     flag_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        active = (pulse_q == EVT_PULSE);
        flag   = (flag_q == FLAG_SET);
    end

    AST_PULSE_ENDS:  assert property (@(posedge clk) disable iff (!rst_n)
                         !hit |=> !active);                          // R3
    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
                         hit |=> active);                            // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                         (flag && !clr) |=> flag);                   // R4
    AST_FLAG_SETWIN: assert property (@(posedge clk) disable iff (!rst_n)
                         hit |=> flag);                              // R9

endmodule

// File: rtl/tz_out_mux.sv
module tz_out_mux
    import tz_pkg::*;
(
    input  logic       pwm,
    input  logic       ost_on,
    input  logic       evt_on,
    input  logic [1:0] act_ost,
    input  logic [1:0] act_evt,
    output logic       drv,
    output logic       oe
);

    logic [1:0] sel;

    always_comb begin
        if (ost_on)      sel = act_ost;
        else if (evt_on) sel = act_evt;
        else             sel = ACT_PASS;
    end

    always_comb begin
        unique case (tz_act_e'(sel))
            ACT_HIZ:  begin oe = 1'b0; drv = 1'b0; end
            ACT_HIGH: begin oe = 1'b1; drv = 1'b1; end
            ACT_LOW:  begin oe = 1'b1; drv = 1'b0; end
            ACT_PASS: begin oe = 1'b1; drv = pwm;  end
            default:  begin oe = 1'b1; drv = pwm;  end
        endcase
    end

endmodule

// File: rtl/tz_override.sv
module tz_override
    import tz_pkg::*;
#(
    parameter int NUM_OUT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_OUT-1:0]   pwm_in,
    input  logic [2*NUM_OUT-1:0] act_ost,
    input  logic [2*NUM_OUT-1:0] act_evt,
    input  logic                 ost_in,
    input  logic                 frc_ost,
    input  logic                 clr_ost,
    input  logic [NUM_OUT-1:0]   evt_in,
    input  logic [NUM_OUT-1:0]   frc_evt,
    input  logic [NUM_OUT-1:0]   clr_evt,
    output logic [NUM_OUT-1:0]   pin_drv,
    output logic [NUM_OUT-1:0]   pin_oe,
    output logic [NUM_OUT:0]     status
);

    localparam int ACT_W = 2;

    logic               ost_on;
    logic [NUM_OUT-1:0] evt_on;
    logic [NUM_OUT-1:0] evt_flag;

    tz_ost_latch u_ost (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip_in (ost_in),
        .frc     (frc_ost),
        .clr     (clr_ost),
        .latched (ost_on)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        tz_evt_chan u_evt (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_in (evt_in[i]),
            .frc    (frc_evt[i]),
            .clr    (clr_evt[i]),
            .active (evt_on[i]),
            .flag   (evt_flag[i])
        );

        tz_out_mux u_mux (
            .pwm     (pwm_in[i]),
            .ost_on  (ost_on),
            .evt_on  (evt_on[i]),
            .act_ost (act_ost[ACT_W*i +: ACT_W]),
            .act_evt (act_evt[ACT_W*i +: ACT_W]),
            .drv     (pin_drv[i]),
            .oe      (pin_oe[i])
        );

        AST_IDLE_PASS:  assert property (@(posedge clk) disable iff (!rst_n)
                            (!ost_on && !evt_on[i]) |-> (pin_oe[i] && (pin_drv[i] == pwm_in[i]))); // R1
        AST_OST_WINS:   assert property (@(posedge clk) disable iff (!rst_n)
                            (ost_on && evt_on[i] && act_ost[ACT_W*i +: ACT_W] == ACT_HIZ
                             && act_evt[ACT_W*i +: ACT_W] != ACT_HIZ) |-> !pin_oe[i]);            // R8
        AST_HIZ_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
                            !pin_oe[i] |-> !pin_drv[i]);                                           // R2
    end

    assign status = {evt_flag, ost_on};

endmodule

// File: tb/tb_tz_override.sv
`timescale 1ns/1ps
module tb_tz_override;
    localparam int N = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   pwm_in = '0;
    logic [2*N-1:0] act_ost = '1;
    logic [2*N-1:0] act_evt = '1;
    logic           ost_in = 1'b0, frc_ost = 1'b0, clr_ost = 1'b0;
    logic [N-1:0]   evt_in = '0, frc_evt = '0, clr_evt = '0;
    logic [N-1:0]   pin_drv, pin_oe;
    logic [N:0]     status;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    tz_override #(.NUM_OUT(N)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .act_ost(act_ost), .act_evt(act_evt),
        .ost_in(ost_in), .frc_ost(frc_ost), .clr_ost(clr_ost), .evt_in(evt_in),
        .frc_evt(frc_evt), .clr_evt(clr_evt), .pin_drv(pin_drv), .pin_oe(pin_oe),
        .status(status)
    );

    // {oe, drv} from the action code table
    function automatic logic [1:0] model(input logic [1:0] code, input logic pwm);
        case (code)
            2'd0:    return 2'b00;
            2'd1:    return 2'b11;
            2'd2:    return 2'b10;
            default: return {1'b1, pwm};
        endcase
    endfunction

    task automatic expect_bits(input string req, input logic [7:0] got, input logic [7:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, want);
        end
    endtask

    task automatic check_pins(input string req, input logic [1:0] ca, input logic [1:0] cb);
        logic [3:0] want;
        want = {model(cb, pwm_in[1]), model(ca, pwm_in[0])};
        expect_bits(req, {4'b0, pin_oe[1], pin_drv[1], pin_oe[0], pin_drv[0]}, {4'b0, want});
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        pwm_in = 2'b10;
        repeat (3) tick();
        // R1 reset state
        expect_bits("R1 status", {5'b0, status}, 8'h0);
        check_pins("R1 pins", 2'd3, 2'd3);
        rst_n = 1'b1;
        tick();

        // Sweep over action codes, PWM level and trip scenario (R2, R8, R6)
        for (int oa = 0; oa < 4; oa++)
            for (int ea = 0; ea < 4; ea++)
                for (int p = 0; p < 4; p++)
                    for (int s = 0; s < 4; s++) begin
                        logic [1:0] oa_b, ea_b, ca, cb;
                        oa_b = 2'((oa + 1) % 4);
                        ea_b = 2'((ea + 2) % 4);
                        act_ost = {oa_b, 2'(oa)};
                        act_evt = {ea_b, 2'(ea)};
                        pwm_in  = 2'(p);
                        frc_evt = s[0] ? 2'b11 : 2'b00;
                        frc_ost = s[1];
                        tick();
                        frc_evt = '0;
                        frc_ost = 1'b0;
                        ca = s[1] ? 2'(oa) : (s[0] ? 2'(ea) : 2'd3);
                        cb = s[1] ? oa_b   : (s[0] ? ea_b   : 2'd3);
                        check_pins("R2/R8 sweep pins", ca, cb);
                        expect_bits("R4/R5 sweep status", {5'b0, status},
                                    {5'b0, s[0], s[0], s[1]});
                        clr_ost = 1'b1;
                        clr_evt = 2'b11;
                        tick();
                        clr_ost = 1'b0;
                        clr_evt = '0;
                        check_pins("R3 sweep release", 2'd3, 2'd3);
                        expect_bits("R4 sweep cleared", {5'b0, status}, 8'h0);
                    end

        // R3 / R6 single-cycle pulse on channel A only
        pwm_in  = 2'b11;
        act_ost = 4'hF;
        act_evt = {2'd3, 2'd0};
        frc_evt = 2'b01;
        tick();
        frc_evt = '0;
        check_pins("R6 pulse on A only", 2'd0, 2'd3);
        tick();
        check_pins("R3 pulse ends after one cycle", 2'd3, 2'd3);
        expect_bits("R4 flag A stays", {5'b0, status}, 8'h02);
        repeat (5) tick();
        expect_bits("R4 flag A still set", {5'b0, status}, 8'h02);
        clr_evt = 2'b01;
        tick();
        clr_evt = '0;
        expect_bits("R4 flag A cleared", {5'b0, status}, 8'h0);

        // R10 external event, no combinational path
        pwm_in  = 2'b00;
        act_evt = {2'd1, 2'd0};
        evt_in  = 2'b10;
        #0.5;
        check_pins("R10 no path before edge", 2'd3, 2'd3);
        tick();
        evt_in = '0;
        check_pins("R10 event after edge", 2'd3, 2'd1);
        expect_bits("R6 only flag B", {5'b0, status}, 8'h04);
        clr_evt = 2'b10;
        tick();
        clr_evt = '0;

        // R5 latch held, R7 live action change
        act_ost = {2'd2, 2'd2};
        ost_in  = 1'b1;
        tick();
        ost_in = 1'b0;
        repeat (10) tick();
        check_pins("R5 latch holds", 2'd2, 2'd2);
        expect_bits("R5 latch status", {5'b0, status}, 8'h01);
        act_ost = {2'd0, 2'd1};
        #0.5;
        check_pins("R7 immediate action change", 2'd1, 2'd0);

        // R9 clear and set together
        clr_ost = 1'b1;
        frc_ost = 1'b1;
        tick();
        frc_ost = 1'b0;
        expect_bits("R9 latch set wins", {5'b0, status}, 8'h01);
        tick();
        clr_ost = 1'b0;
        expect_bits("R5 latch cleared", {5'b0, status}, 8'h0);
        check_pins("R5 pins released", 2'd3, 2'd3);
        frc_evt = 2'b01;
        clr_evt = 2'b01;
        tick();
        frc_evt = '0;
        clr_evt = '0;
        expect_bits("R9 flag set wins", {5'b0, status}, 8'h02);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule